// File: doc/BRIEF.md
# Lead-Device Serial Configuration Loader

This block sits at the head of a chain of serially configured devices. It makes a slow configuration clock from the system clock and sends it to an external serial memory. On each rising edge of that clock the memory steps to its next bit, and the block reads the bit on its data input. The block first looks for a fixed start pattern and then reads a 24-bit total length. It keeps the next group of bits as its own frame and shows them on a parallel output.

Every header bit, and every bit after the block's own frame, goes out again on a chain output for the next device. That output lags the capture by one and a half configuration-clock periods and changes only on a falling edge. The next device can therefore sample it on the rising edge that follows.

Once the number of bits seen equals the length value, a loading-low output and a done output both go high. Either can serve as the memory enable. The configuration clock then runs one more period and stops low.

Top module: `cfg_chain_loader`

## Requirements
- R1: While loading, `cclk` is a square wave. Each high level and each low level lasts DIV_HALF system cycles. The first rising edge comes DIV_HALF cycles after reset is released.
- R2: `din` is sampled in the system cycle in which `cclk` goes from 0 to 1, using the value present before that edge. The memory may move on after the edge.
- R3: During the hunt, sampled bits are compared MSB first with PREAMBLE (default 8'h2D).
  - If a bit matches, the pattern index advances.
  - If a bit does not match, the index restarts at 1 when the bit equals PREAMBLE's MSB, and at 0 otherwise.
- R4: The LEN_W bits after the start pattern, MSB first, form the length N. N counts every bit from the first start-pattern bit onward.
- R5: The OWN_W bits after the length go into `own_data` with the first bit in the MSB. `dout` is 1 in the slot of each of these bits.
- R6: Bits are forwarded as follows:
  - Start-pattern bits and length bits are forwarded unchanged.
  - Bits after the own frame are forwarded unchanged.
  - A hunt bit that matches the expected pattern bit is forwarded; a hunt bit that does not match is forwarded as 1.
- R7: A bit sampled at rising edge k is shown on `dout` from falling edge k+1 onward. `dout` changes only in the cycle in which `cclk` falls.
- R8: `done` and `ldc` are low while loading. Both go high together at the rising edge that samples bit N, and they stay high until reset.
- R9: After `done` rises, `cclk` makes exactly one more rising edge, then falls and stays low.
- R10: Reset gives `cclk`=0, `dout`=1, `ldc`=0, `done`=0 and `own_data`=0. Loading then restarts from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data from the configuration memory |
| cclk | output | 1 | Configuration clock to the memory and to downstream devices |
| dout | output | 1 | Chain output carrying the forwarded bits |
| ldc | output | 1 | Low while loading, high once loading is complete |
| done | output | 1 | High once the length count has been reached |
| own_data | output | OWN_W | Parallel copy of this device's own frame |

## Verification
The assertions check four things on every cycle:
- `dout` moves only on a falling edge of `cclk`.
- The load state changes only on a rising-edge strobe.
- `done` and `ldc` never drop once set.
- `cclk` stays low once the clock has stopped.

Only the bench's scenarios can show the data-dependent behaviour:
- the exact 1.5-period alignment of each forwarded bit;
- the start-pattern restart after a partial match;
- the length count ending the load on the right bit;
- the own frame landing in `own_data`;
- exactly one trailing clock period.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_LEN  = 3'd1,
    ST_OWN  = 3'd2,
    ST_FWD  = 3'd3,
    ST_DONE = 3'd4
  } load_st_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic cclk,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          cclk_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_now = run && wrap && !cclk_q;
  assign fall_now = run && wrap && cclk_q;
  assign cclk     = cclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);
      if (wrap) cclk_q <= !cclk_q;
    end
  end

  // R9: a stopped clock stays low
  p_stopped_low_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !cclk);
endmodule

// File: rtl/cfg_frame_ctl.sv
module cfg_frame_ctl
  import cfg_chain_pkg::*;
#(
  parameter int               PRE_W    = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'h2D,
  parameter int               LEN_W    = 24,
  parameter int               OWN_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_now,
  input  logic             fall_now,
  input  logic             din,
  output logic             run,
  output logic             fwd_val,
  output logic             done,
  output logic             ldc,
  output logic [OWN_W-1:0] own_data
);
  localparam int PIW     = (PRE_W > 1) ? $clog2(PRE_W) : 1;
  localparam int HDR     = PRE_W + LEN_W;
  localparam int OWN_END = HDR + OWN_W;

  load_st_e         st_q;
  logic [LEN_W-1:0] bitcnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [OWN_W-1:0] own_q;
  logic             done_q, ldc_q, run_q, tail_q;
  logic [PIW-1:0]   pidx;
  logic             exp_bit;

  assign pidx    = bitcnt_q[PIW-1:0];
  assign exp_bit = PREAMBLE[PIW'(PRE_W - 1) - pidx];
  assign cnt_nxt = bitcnt_q + LEN_W'(1);

  always_comb begin
    case (st_q)
      ST_HUNT:        fwd_val = (din == exp_bit) ? din : 1'b1;
      ST_LEN, ST_FWD: fwd_val = din;
      default:        fwd_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_HUNT;
      bitcnt_q <= '0;
      len_q    <= '0;
      own_q    <= '0;
      done_q   <= 1'b0;
      ldc_q    <= 1'b0;
      run_q    <= 1'b1;
      tail_q   <= 1'b0;
    end else begin
      if (rise_now) begin
        case (st_q)
          ST_HUNT: begin
            if (din == exp_bit) begin
              bitcnt_q <= cnt_nxt;
              if (bitcnt_q == LEN_W'(PRE_W - 1)) st_q <= ST_LEN;
            end else begin
              bitcnt_q <= (din == PREAMBLE[PRE_W-1]) ? LEN_W'(1) : '0;
            end
          end
          ST_LEN: begin
            len_q    <= {len_q[LEN_W-2:0], din};
            bitcnt_q <= cnt_nxt;
            if (bitcnt_q == LEN_W'(HDR - 1)) st_q <= ST_OWN;
          end
          ST_OWN, ST_FWD: begin
            bitcnt_q <= cnt_nxt;
            if (st_q == ST_OWN) own_q <= {own_q[OWN_W-2:0], din};
            if (cnt_nxt == len_q) begin
              st_q   <= ST_DONE;
              done_q <= 1'b1;
              ldc_q  <= 1'b1;
            end else if (st_q == ST_OWN && bitcnt_q == LEN_W'(OWN_END - 1)) begin
              st_q <= ST_FWD;
            end
          end
          default: ;
        endcase
      end
      if (fall_now && st_q == ST_DONE) begin
        if (tail_q) run_q <= 1'b0;
        else        tail_q <= 1'b1;
      end
    end
  end

  assign run      = run_q;
  assign done     = done_q;
  assign ldc      = ldc_q;
  assign own_data = own_q;

  // R2: the load state only moves on a rising configuration-clock strobe
  p_state_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    !rise_now |=> $stable(st_q));
  // R8: completion flags are sticky until reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_ldc_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ldc |=> ldc);
endmodule

// File: rtl/cfg_fwd_delay.sv
module cfg_fwd_delay (
  input  logic clk,
  input  logic rst,
  input  logic rise_now,
  input  logic fall_now,
  input  logic fwd_val,
  output logic dout
);
  logic cap_q, hold_q, dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= 1'b1;
      hold_q <= 1'b1;
      dout_q <= 1'b1;
    end else begin
      if (rise_now) begin
        cap_q  <= fwd_val;
        hold_q <= cap_q;
      end
      if (fall_now) dout_q <= hold_q;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int               DIV_HALF = 4,
  parameter int               PRE_W    = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'h2D,
  parameter int               LEN_W    = 24,
  parameter int               OWN_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic             cclk,
  output logic             dout,
  output logic             ldc,
  output logic             done,
  output logic [OWN_W-1:0] own_data
);
  logic run, rise_now, fall_now, fwd_val;

  cfg_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst(rst), .run(run),
    .cclk(cclk), .rise_now(rise_now), .fall_now(fall_now)
  );

  cfg_frame_ctl #(
    .PRE_W(PRE_W), .PREAMBLE(PREAMBLE), .LEN_W(LEN_W), .OWN_W(OWN_W)
  ) u_frame (
    .clk(clk), .rst(rst), .rise_now(rise_now), .fall_now(fall_now),
    .din(din), .run(run), .fwd_val(fwd_val),
    .done(done), .ldc(ldc), .own_data(own_data)
  );

  cfg_fwd_delay u_fwd (
    .clk(clk), .rst(rst), .rise_now(rise_now), .fall_now(fall_now),
    .fwd_val(fwd_val), .dout(dout)
  );

  // R7: the chain output only moves together with a falling cclk
  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !$fell(cclk) |-> $stable(dout));
endmodule

// File: tb/test_cfg_chain_loader.sv
`timescale 1ns/1ps
module test_cfg_chain_loader;
  localparam int DIV_HALF = 4;
  localparam int PRE_W = 8;
  localparam logic [7:0] PRE = 8'h2D;
  localparam int LEN_W = 24;
  localparam int OWN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din, cclk, dout, ldc, done;
  logic [OWN_W-1:0] own_data;

  always #2.5 clk = ~clk;

  cfg_chain_loader #(.DIV_HALF(DIV_HALF), .PRE_W(PRE_W), .PREAMBLE(PRE),
                     .LEN_W(LEN_W), .OWN_W(OWN_W)) i_cfg_chain_loader (
    .clk(clk), .rst(rst), .din(din), .cclk(cclk), .dout(dout),
    .ldc(ldc), .done(done), .own_data(own_data));

  // serial memory model: steps on each rising cclk
  bit mem [0:511];
  bit fw  [0:511];
  int mem_len = 0;
  int addr;
  always @(posedge cclk or posedge rst)
    if (rst) addr <= 0; else addr <= addr + 1;
  assign din = (addr < mem_len) ? mem[addr] : 1'b1;

  typedef struct { logic d; logic dn; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  realtime t_rise = 0, t_fall = 0;
  bit have_fall = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input bit b, input bit f);
    mem[mem_len] = b; fw[mem_len] = f; mem_len++;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // low-level width on each rise (R1)
  always @(posedge cclk) begin
    if (have_fall) chk("R1 low width x10ns", int'((($realtime - t_fall)) * 10.0), DIV_HALF * 50);
    t_rise = $realtime;
  end

  // monitor: pop one expected item per falling cclk
  always begin
    @(negedge cclk);
    t_fall = $realtime;
    have_fall = 1;
    @(negedge clk);
    chk("R1 high width x10ns", int'((t_fall - t_rise) * 10.0), DIV_HALF * 50);
    if (q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R9 extra falling cclk actual=1 expected=0 at %0t", $time);
    end else begin
      exp_t e;
      e = q.pop_front();
      chk("R3/R5/R6/R7 dout", dout, e.d);
      chk("R4/R8 done", done, e.dn);
      chk("R8 ldc", ldc, e.dn);
    end
  end

  task automatic run_frame(input int filler, input bit bad, input int n,
                           input logic [OWN_W-1:0] own);
    int s;
    int start;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    chk("R10 cclk", cclk, 0);
    chk("R10 dout", dout, 1);
    chk("R10 ldc", ldc, 0);
    chk("R10 done", done, 0);
    chk("R10 own_data", own_data, 0);
    mem_len = 0;
    q.delete();
    have_fall = 0;
    for (int i = 0; i < filler; i++) put(1'b1, 1'b1);
    if (bad) begin put(0, 0); put(0, 0); put(1, 1); put(1, 1); end
    start = mem_len;
    for (int i = PRE_W - 1; i >= 0; i--) put(PRE[i], PRE[i]);
    for (int i = LEN_W - 1; i >= 0; i--) put(n[i], n[i]);
    for (int i = OWN_W - 1; i >= 0; i--) put(own[i], 1'b1);
    while (mem_len - start < n) begin
      bit b;
      b = (((mem_len * 7) + n) % 5) < 2;
      put(b, b);
    end
    s = mem_len;
    q.push_back('{d: 1'b1, dn: 1'b0});
    for (int k = 1; k <= s; k++) q.push_back('{d: fw[k-1], dn: (k >= s - 1)});
    @(negedge clk);
    rst = 1'b0;
    while (q.size() > 0) @(posedge clk);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R9 cclk stopped low", cclk, 0);
    chk("R8 done held", done, 1);
    chk("R8 ldc held", ldc, 1);
    chk("R2/R5 own_data", own_data, own);
    chk("R7 last dout", dout, fw[s-1]);
  endtask

  initial begin
    run_frame(4, 1'b0, 68, 16'hA5C3);
    run_frame(3, 1'b1, 60, 16'h1E07);
    run_frame(2, 1'b0, 48, 16'hFF00);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 final reset done", done, 0);
    chk("R10 final reset ldc", ldc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule